// File: doc/BRIEF.md
# Interrupt Redirection Table Dispatcher

This block routes up to 160 interrupt sources to the hardware threads of a four-node system. Each node has eight cores with four threads, so there are 128 threads in all. Every source owns one 32-bit routing entry. The entry says whether the source is live, which vector to present, whether the delivery is non-maskable, and where it goes.

An entry can name its targets in one of two ways. In direct mode it picks a node and a half of that node's cores, and supplies a 16-bit thread mask inside that half. In indirect mode it names one of eight shared thread-group registers. Each group register holds a 32-bit mask for each of the four nodes.

A source that fires while its entry is live becomes pending. Pending sources are dispatched lowest index first, one per clock. A dispatched source stays parked until software acknowledges it by index. Sources 0–11 (the watchdogs and the system timers) also set a status bit, and the same acknowledge clears it. A dispatch either reaches every thread in the resolved mask, or reaches a single thread chosen in rotation.

Top module: `irt_dispatch`

## Requirements
- R1: A routing entry is decoded as follows: bit 31 enable, bit 29 NMI, bit 28 single-target (rotate) flag, bits 25:20 vector, bit 19 destination type, bits 18:16 destination base, bits 15:0 thread mask. Bits 30 and 27:26 are ignored. A delivery presents the vector and the NMI flag of the entry of the dispatched source.
- R2: With destination type 1, base bits 2:1 select node n and base bit 0 selects half h. Mask bit k then targets global thread n*32 + h*16 + k, where thread t of core c on node n is numbered n*32 + 4*c + t.
- R3: With destination type 0, the base selects one of eight group registers. Bit b of the node-n word of that group targets global thread n*32 + b. A group word is written with its group index and its node index.
- R4: A source that asserts while its entry is disabled is neither delivered nor held pending, and it does not set its status bit. Enabling the entry later delivers nothing.
- R5: Pending sources are dispatched lowest index first, with at most one dispatch per clock.
- R6: A dispatched source is not delivered again until it is acknowledged by writing its index. A source that is still asserted after its acknowledge is captured and delivered again.
- R7: When the rotate flag is set, exactly one thread of the resolved mask receives the delivery. That thread is the first set bit at or above a rotation pointer, wrapping around. The pointer then moves to the chosen thread plus one (modulo 128). It is 0 after reset and changes only on rotated deliveries.
- R8: When the rotate flag is clear, every thread of the resolved mask receives the delivery.
- R9: For sources 0–11, capture sets status bit [index] and the acknowledge of that index clears it.
- R10: A source sampled high at clock edge E is delivered on the outputs after edge E+1, for exactly one cycle, together with its source index.
- R11: After reset all entries are disabled and nothing is pending. The outputs and the status bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | N_SRC | Interrupt source levels |
| tbl_we | input | 1 | Routing entry write strobe |
| tbl_idx | input | IDXW | Entry index for the write |
| tbl_data | input | 32 | Entry contents |
| grp_we | input | 1 | Group register write strobe |
| grp_sel | input | 3 | Group register index |
| grp_node | input | 2 | Node word within the group |
| grp_data | input | 32 | Thread mask for that node |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | IDXW | Source index being acknowledged |
| dlv_valid | output | 1 | Delivery strobe |
| dlv_threads | output | 128 | Threads receiving the delivery |
| dlv_vec | output | 6 | Delivered vector |
| dlv_nmi | output | 1 | Delivery is non-maskable |
| dlv_src | output | IDXW | Source index delivered |
| tmr_status | output | N_STATUS | Watchdog and timer status bits |

## Verification
The assertions check the following on every cycle:
- a dispatched index never had a lower-numbered source still waiting;
- a source leaves the waiting set once it is dispatched;
- an acknowledge clears both the pending state and the status bit;
- no source turns pending without its enable;
- a rotated delivery never reaches more than one thread.

Some behaviours only the bench scenarios can show. These are the mapping of direct and indirect modes onto global thread numbers, the exact rotation order across repeated deliveries, and redelivery of a source held high through its acknowledge. The two-cycle latency also depends on the scenarios, as does the absence of any delivery after a disabled source is later enabled.

// File: rtl/irt_pkg.sv
`timescale 1ns/1ps
package irt_pkg;
  localparam int NODES        = 4;
  localparam int THR_PER_NODE = 32;
  localparam int HALF_THR     = THR_PER_NODE / 2;
  localparam int GROUPS       = 8;
  localparam int ENTRY_W      = 32;
  localparam int VEC_W        = 6;
  localparam int TOTAL_THR    = NODES * THR_PER_NODE;
  localparam int THR_W        = $clog2(TOTAL_THR);
  localparam int GRP_W        = $clog2(GROUPS);
  localparam int NODE_W       = $clog2(NODES);

  typedef struct packed {
    logic              en;
    logic              rsv_a;
    logic              nmi;
    logic              rotate;
    logic [1:0]        rsv_b;
    logic [VEC_W-1:0]  vec;
    logic              direct;
    logic [2:0]        base;
    logic [HALF_THR-1:0] mask;
  } route_entry_t;
endpackage

// File: rtl/irt_table.sv
`timescale 1ns/1ps
module irt_table import irt_pkg::*; #(
  parameter int N_SRC = 160,
  parameter int IDXW  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDXW-1:0]     wr_idx,
  input  logic [ENTRY_W-1:0]  wr_data,
  input  logic [IDXW-1:0]     rd_idx,
  output logic                rd_nmi,
  output logic                rd_rotate,
  output logic [VEC_W-1:0]    rd_vec,
  output logic                rd_direct,
  output logic [2:0]          rd_base,
  output logic [HALF_THR-1:0] rd_mask,
  output logic [N_SRC-1:0]    en_vec
);
  route_entry_t mem [N_SRC];
  route_entry_t rd_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SRC; i++) mem[i] <= '0;
    end else if (wr_en && (int'(wr_idx) < N_SRC)) begin
      mem[wr_idx] <= route_entry_t'(wr_data);
    end
  end

  always_comb begin
    rd_e = '0;
    if (int'(rd_idx) < N_SRC) rd_e = mem[rd_idx];
  end

  assign rd_nmi    = rd_e.nmi;
  assign rd_rotate = rd_e.rotate;
  assign rd_vec    = rd_e.vec;
  assign rd_direct = rd_e.direct;
  assign rd_base   = rd_e.base;
  assign rd_mask   = rd_e.mask;

  for (genvar g = 0; g < N_SRC; g++) begin : g_en
    assign en_vec[g] = mem[g].en;
  end
endmodule

// File: rtl/irt_groups.sv
`timescale 1ns/1ps
module irt_groups import irt_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [GRP_W-1:0]     wr_grp,
  input  logic [NODE_W-1:0]    wr_node,
  input  logic [THR_PER_NODE-1:0] wr_data,
  input  logic [GRP_W-1:0]     rd_grp,
  output logic [TOTAL_THR-1:0] rd_flat
);
  logic [THR_PER_NODE-1:0] grp [GROUPS][NODES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < GROUPS; g++)
        for (int n = 0; n < NODES; n++) grp[g][n] <= '0;
    end else if (wr_en) begin
      grp[wr_grp][wr_node] <= wr_data;
    end
  end

  for (genvar n = 0; n < NODES; n++) begin : g_node
    assign rd_flat[n*THR_PER_NODE +: THR_PER_NODE] = grp[rd_grp][n];
  end
endmodule

// File: rtl/irt_pend.sv
`timescale 1ns/1ps
module irt_pend #(
  parameter int N_SRC    = 160,
  parameter int IDXW     = 8,
  parameter int N_STATUS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_SRC-1:0]    src_irq,
  input  logic [N_SRC-1:0]    en_vec,
  input  logic                ack_valid,
  input  logic [IDXW-1:0]     ack_idx,
  output logic                pick_valid,
  output logic [IDXW-1:0]     pick_idx,
  output logic [N_STATUS-1:0] tmr_status
);
  logic [N_SRC-1:0] waiting, served;
  logic [N_SRC-1:0] ack_vec, cap_vec, pick_vec;
  int               low_i;

  function automatic int lowest_set(input logic [N_SRC-1:0] v);
    for (int i = 0; i < N_SRC; i++) if (v[i]) return i;
    return -1;
  endfunction

  always_comb begin
    low_i      = lowest_set(waiting);
    pick_valid = (low_i >= 0);
    pick_idx   = pick_valid ? IDXW'(low_i) : '0;
    for (int i = 0; i < N_SRC; i++) begin
      ack_vec[i]  = ack_valid && (int'(ack_idx) == i);
      pick_vec[i] = pick_valid && (low_i == i);
    end
    // ack wins over a same-cycle capture
    cap_vec = src_irq & en_vec & ~waiting & ~served & ~ack_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting    <= '0;
      served     <= '0;
      tmr_status <= '0;
    end else begin
      waiting    <= (waiting & ~pick_vec & ~ack_vec) | cap_vec;
      served     <= (served | pick_vec) & ~ack_vec;
      tmr_status <= (tmr_status & ~ack_vec[N_STATUS-1:0]) | cap_vec[N_STATUS-1:0];
    end
  end

  assert_lowest_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> ((waiting & ((N_SRC'(1) << pick_idx) - N_SRC'(1))) == '0));

  assert_served_leaves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |=> !waiting[$past(pick_idx)]);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && int'(ack_idx) < N_SRC) |=>
      (!waiting[$past(ack_idx)] && !served[$past(ack_idx)]));

  assert_status_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && int'(ack_idx) < N_STATUS) |=> !tmr_status[$past(ack_idx)]);

  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    assert_disabled_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(waiting[g]) |-> $past(en_vec[g]));
  end
endmodule

// File: rtl/irt_route.sv
`timescale 1ns/1ps
module irt_route import irt_pkg::*; #(
  parameter int IDXW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [IDXW-1:0]      src_idx,
  input  logic                 e_nmi,
  input  logic                 e_rotate,
  input  logic [VEC_W-1:0]     e_vec,
  input  logic                 e_direct,
  input  logic [2:0]           e_base,
  input  logic [HALF_THR-1:0]  e_mask,
  input  logic [TOTAL_THR-1:0] grp_flat,
  output logic                 dlv_valid,
  output logic [TOTAL_THR-1:0] dlv_threads,
  output logic [VEC_W-1:0]     dlv_vec,
  output logic                 dlv_nmi,
  output logic [IDXW-1:0]      dlv_src
);
  logic [THR_W-1:0]     rr_ptr;
  logic [TOTAL_THR-1:0] resolved, one_hot, chosen;
  logic                 dlv_rot;
  int                   pick;

  function automatic logic [TOTAL_THR-1:0] direct_expand(input logic [2:0] base,
                                                         input logic [HALF_THR-1:0] m);
    logic [TOTAL_THR-1:0] r;
    int off;
    r   = '0;
    off = int'(base[2:1]) * THR_PER_NODE + int'(base[0]) * HALF_THR;
    r[off +: HALF_THR] = m;
    return r;
  endfunction

  function automatic int rotate_pick(input logic [TOTAL_THR-1:0] m, input logic [THR_W-1:0] p);
    for (int k = 0; k < TOTAL_THR; k++) begin
      int t;
      t = (int'(p) + k) % TOTAL_THR;
      if (m[t]) return t;
    end
    return -1;
  endfunction

  always_comb begin
    resolved = e_direct ? direct_expand(e_base, e_mask) : grp_flat;
    pick     = rotate_pick(resolved, rr_ptr);
    one_hot  = '0;
    if (pick >= 0) one_hot[pick] = 1'b1;
    chosen   = e_rotate ? one_hot : resolved;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr      <= '0;
      dlv_valid   <= 1'b0;
      dlv_threads <= '0;
      dlv_vec     <= '0;
      dlv_nmi     <= 1'b0;
      dlv_src     <= '0;
      dlv_rot     <= 1'b0;
    end else begin
      dlv_valid   <= fire;
      dlv_threads <= fire ? chosen : '0;
      dlv_vec     <= fire ? e_vec : '0;
      dlv_nmi     <= fire && e_nmi;
      dlv_src     <= fire ? src_idx : '0;
      dlv_rot     <= fire && e_rotate;
      if (fire && e_rotate && pick >= 0)
        rr_ptr <= THR_W'((pick + 1) % TOTAL_THR);
    end
  end

  assert_one_thread_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_rot) |-> $onehot0(dlv_threads));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dlv_valid |-> (dlv_threads == '0 && !dlv_nmi));
endmodule

// File: rtl/irt_dispatch.sv
`timescale 1ns/1ps
module irt_dispatch import irt_pkg::*; #(
  parameter int N_SRC    = 160,
  parameter int N_STATUS = 12,
  localparam int IDXW    = $clog2(N_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SRC-1:0]     src_irq,
  input  logic                 tbl_we,
  input  logic [IDXW-1:0]      tbl_idx,
  input  logic [31:0]          tbl_data,
  input  logic                 grp_we,
  input  logic [2:0]           grp_sel,
  input  logic [1:0]           grp_node,
  input  logic [31:0]          grp_data,
  input  logic                 ack_valid,
  input  logic [IDXW-1:0]      ack_idx,
  output logic                 dlv_valid,
  output logic [127:0]         dlv_threads,
  output logic [5:0]           dlv_vec,
  output logic                 dlv_nmi,
  output logic [IDXW-1:0]      dlv_src,
  output logic [N_STATUS-1:0]  tmr_status
);
  logic [N_SRC-1:0]     en_vec;
  logic                 pick_valid;
  logic [IDXW-1:0]      pick_idx;
  logic                 e_nmi, e_rotate, e_direct;
  logic [VEC_W-1:0]     e_vec;
  logic [2:0]           e_base;
  logic [HALF_THR-1:0]  e_mask;
  logic [TOTAL_THR-1:0] grp_flat;

  irt_table #(.N_SRC(N_SRC), .IDXW(IDXW)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_data(tbl_data),
    .rd_idx(pick_idx), .rd_nmi(e_nmi), .rd_rotate(e_rotate), .rd_vec(e_vec),
    .rd_direct(e_direct), .rd_base(e_base), .rd_mask(e_mask), .en_vec(en_vec));

  irt_groups u_groups (
    .clk(clk), .rst_n(rst_n), .wr_en(grp_we), .wr_grp(grp_sel), .wr_node(grp_node),
    .wr_data(grp_data), .rd_grp(e_base), .rd_flat(grp_flat));

  irt_pend #(.N_SRC(N_SRC), .IDXW(IDXW), .N_STATUS(N_STATUS)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .en_vec(en_vec),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .pick_valid(pick_valid),
    .pick_idx(pick_idx), .tmr_status(tmr_status));

  irt_route #(.IDXW(IDXW)) u_route (
    .clk(clk), .rst_n(rst_n), .fire(pick_valid), .src_idx(pick_idx),
    .e_nmi(e_nmi), .e_rotate(e_rotate), .e_vec(e_vec), .e_direct(e_direct),
    .e_base(e_base), .e_mask(e_mask), .grp_flat(grp_flat),
    .dlv_valid(dlv_valid), .dlv_threads(dlv_threads), .dlv_vec(dlv_vec),
    .dlv_nmi(dlv_nmi), .dlv_src(dlv_src));

  assert_src_was_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> $past(pick_valid));
endmodule

// File: tb/tb_irt_dispatch.sv
`timescale 1ns/1ps
module tb_irt_dispatch;
  logic         clk = 0, rst_n = 0;
  logic [159:0] src_irq = '0;
  logic         tbl_we = 0, grp_we = 0, ack_valid = 0;
  logic [7:0]   tbl_idx = '0, ack_idx = '0;
  logic [31:0]  tbl_data = '0, grp_data = '0;
  logic [2:0]   grp_sel = '0;
  logic [1:0]   grp_node = '0;
  logic         dlv_valid, dlv_nmi;
  logic [127:0] dlv_threads;
  logic [5:0]   dlv_vec;
  logic [7:0]   dlv_src;
  logic [11:0]  tmr_status;

  int errors = 0, checks = 0, m_ptr = 0;
  bit done = 0;
  logic [31:0] m_tbl [160];
  logic [31:0] m_grp [8][4];

  always #2.5 clk = ~clk;

  irt_dispatch dut (.*);

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit en, nmi, rot, input logic [5:0] vec,
                                     input bit dir, input logic [2:0] base, input logic [15:0] m);
    return {en, 1'b0, nmi, rot, 2'b00, vec, dir, base, m};
  endfunction

  task automatic wr_tbl(input int idx, input logic [31:0] d);
    tbl_we = 1; tbl_idx = 8'(idx); tbl_data = d; tick; tbl_we = 0;
    m_tbl[idx] = d;
  endtask

  task automatic wr_grp(input int g, input int n, input logic [31:0] d);
    grp_we = 1; grp_sel = 3'(g); grp_node = 2'(n); grp_data = d; tick; grp_we = 0;
    m_grp[g][n] = d;
  endtask

  task automatic ack(input int idx);
    ack_valid = 1; ack_idx = 8'(idx); tick; ack_valid = 0;
  endtask

  // thread numbering: node*32 + core*4 + thread
  function automatic logic [127:0] exp_res(input logic [31:0] e);
    logic [127:0] r;
    r = '0;
    if (e[19]) begin
      for (int k = 0; k < 16; k++)
        if (e[k]) r[int'(e[18:17]) * 32 + int'(e[16]) * 16 + k] = 1'b1;
    end else begin
      for (int n = 0; n < 4; n++) r[n*32 +: 32] = m_grp[e[18:16]][n];
    end
    return r;
  endfunction

  task automatic exp_threads(input logic [31:0] e, output logic [127:0] t);
    logic [127:0] r;
    r = exp_res(e);
    t = r;
    if (e[28]) begin
      t = '0;
      for (int k = 0; k < 128; k++) begin
        int p;
        p = (m_ptr + k) % 128;
        if (r[p]) begin t[p] = 1'b1; m_ptr = (p + 1) % 128; break; end
      end
    end
  endtask

  task automatic check_out(input int idx, input string req);
    logic [127:0] t;
    exp_threads(m_tbl[idx], t);
    chk({req, " R10 valid"}, 128'(dlv_valid), 128'(1));
    chk({req, " R10 src"}, 128'(dlv_src), 128'(idx));
    chk({req, " R1 vec"}, 128'(dlv_vec), 128'(m_tbl[idx][25:20]));
    chk({req, " R1 nmi"}, 128'(dlv_nmi), 128'(m_tbl[idx][29]));
    chk({req, " threads"}, dlv_threads, t);
  endtask

  task automatic deliver_one(input int idx, input string req);
    src_irq[idx] = 1; tick; src_irq[idx] = 0;
    chk("R10 not yet", 128'(dlv_valid), 128'(0));
    tick;
    check_out(idx, req);
    if (idx < 12) chk("R9 status set", 128'(tmr_status[idx]), 128'(1));
    tick;
    chk("R6 single pulse", 128'(dlv_valid), 128'(0));
    ack(idx);
    if (idx < 12) chk("R9 status cleared", 128'(tmr_status[idx]), 128'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    for (int i = 0; i < 160; i++) m_tbl[i] = '0;
    for (int g = 0; g < 8; g++) for (int n = 0; n < 4; n++) m_grp[g][n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick;
    // R11 reset state
    chk("R11 valid", 128'(dlv_valid), 128'(0));
    chk("R11 threads", dlv_threads, 128'(0));
    chk("R11 status", 128'(tmr_status), 128'(0));
    src_irq[40] = 1; tick; src_irq[40] = 0; tick;
    chk("R11 entries disabled", 128'(dlv_valid), 128'(0));

    // random group contents
    for (int g = 0; g < 8; g++) for (int n = 0; n < 4; n++) wr_grp(g, n, $urandom);

    // R2 direct mode: node 3, upper half, bit 0 -> thread 112
    wr_tbl(9, mk(1, 0, 0, 6'h2a, 1, 3'b111, 16'h0001));
    deliver_one(9, "R2 direct");
    // R2 node 1 lower half, bits 2,5,15 -> threads 34,37,47 (R8 broadcast)
    wr_tbl(61, mk(1, 1, 0, 6'h11, 1, 3'b010, 16'h8024));
    deliver_one(61, "R8 broadcast");
    chk("R2 thread numbering", exp_res(m_tbl[61]), (128'(1) << 34) | (128'(1) << 37) | (128'(1) << 47));

    // R3 group mode: group 5 node 2 -> threads 64 and 95
    for (int n = 0; n < 4; n++) wr_grp(5, n, 32'h0);
    wr_grp(5, 2, 32'h8000_0001);
    wr_tbl(77, mk(1, 0, 0, 6'h3f, 0, 3'd5, 16'hffff));
    deliver_one(77, "R3 group");

    // R7 rotation over a three-thread mask
    wr_tbl(60, mk(1, 0, 1, 6'h05, 1, 3'b010, 16'h8024));
    for (int r = 0; r < 5; r++) deliver_one(60, "R7 rotate");

    // R4 disabled source
    src_irq[3] = 1; src_irq[20] = 1; tick; src_irq[3] = 0; src_irq[20] = 0;
    wr_tbl(20, mk(1, 0, 0, 6'h01, 1, 3'b000, 16'h0001));
    wr_tbl(3, mk(1, 0, 0, 6'h02, 1, 3'b000, 16'h0002));
    for (int c = 0; c < 3; c++) begin
      chk("R4 no delivery", 128'(dlv_valid), 128'(0));
      chk("R4 no status", 128'(tmr_status[3]), 128'(0));
      tick;
    end

    // R5 priority: 7, 30, 100 together
    wr_tbl(7, mk(1, 0, 0, 6'h07, 1, 3'b001, 16'h00f0));
    wr_tbl(30, mk(1, 1, 0, 6'h1e, 0, 3'd2, 16'h0));
    wr_tbl(100, mk(1, 0, 0, 6'h24, 1, 3'b100, 16'h0300));
    src_irq[100] = 1; src_irq[30] = 1; src_irq[7] = 1; tick;
    src_irq[100] = 0; src_irq[30] = 0; src_irq[7] = 0;
    tick; check_out(7, "R5 first");
    tick; check_out(30, "R5 second");
    tick; check_out(100, "R5 third");
    tick; chk("R5 drained", 128'(dlv_valid), 128'(0));
    chk("R9 status 7", 128'(tmr_status), 128'(1) << 7);
    ack(7); ack(30); ack(100);
    chk("R9 status ack", 128'(tmr_status), 128'(0));

    // R6 held source: no repeat until ack, then repeat
    wr_tbl(50, mk(1, 0, 0, 6'h32, 1, 3'b011, 16'h1234));
    src_irq[50] = 1; tick; tick;
    check_out(50, "R6 first");
    for (int c = 0; c < 3; c++) begin
      tick; chk("R6 no repeat", 128'(dlv_valid), 128'(0));
    end
    ack(50);
    chk("R6 ack edge", 128'(dlv_valid), 128'(0));
    tick; chk("R6 recapture", 128'(dlv_valid), 128'(0));
    tick; check_out(50, "R6 redeliver");
    src_irq[50] = 0; tick; ack(50);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int idx;
      idx = $urandom_range(159, 0);
      wr_tbl(idx, mk(1, 1'($urandom), 1'($urandom), 6'($urandom), 1'($urandom),
                     3'($urandom), 16'($urandom)));
      deliver_one(idx, "R1 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule